// File: doc/BRIEF.md
# NAND Flash Host Bridge

This block lets a processor with a 16-bit memory-mapped bus drive an 8-bit raw NAND flash device. A host access to the data port becomes one flash byte cycle for a byte access or two consecutive byte cycles for a word access. The host is held off with a wait signal until every byte cycle has finished. The flash control pins are not decoded from the address. They follow a mode register: software writes a mode value to select command latch, address latch or data transfer. It then moves bytes through the data port.

A ready/busy monitor synchronizes the flash ready line. The current busy state appears in a status register. A low-to-high transition of the ready line is latched as a ready event in an interrupt status register. The event reaches the interrupt output only when the interrupt mask register enables both the event bit and the master bit. Software clears a latched event by writing a one to its position.

Each byte cycle holds its read or write strobe low for `STROBE_CLKS` clocks. The strobe then stays high for `GAP_CLKS` clocks before the next byte or the end of the access.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset the mode register holds 0x00, so `nf_ce_n`=1, `nf_cle`=0, `nf_ale`=0, `nf_wen_n`=1 and `nf_pwr`=00. `bus_wait` and `irq` are 0, and the interrupt status (offset 6) and mask (offset 7) registers read 0.
- R2: The mode register at offset 4 is written from `bus_wdata[7:0]` and reads back its value. Its bits drive the pins: bit 0 drives `nf_cle`, bit 1 drives `nf_ale`, bits 3:2 drive `nf_pwr`, bit 4 drives `nf_ce_n` inverted and bit 7 drives `nf_wen_n` inverted. Example values: 0x95 gives command latch, 0x96 gives address latch, 0x94 gives data, 0x0C gives power on with chip enable released, and 0x00 gives standby.
- R3: A word write to offset 0 (`bus_wide`=1) sends `bus_wdata[7:0]` first and `bus_wdata[15:8]` second. For each byte, `nf_wstb_n` is low for `STROBE_CLKS` clocks and then high for `GAP_CLKS` clocks. `nf_doe` stays 1 and `nf_dout` holds the byte throughout its cycle.
- R4: A word read from offset 0 pulses `nf_rstb_n` the same way as R3. It samples `nf_din` on the last low clock of each strobe. The first byte goes to `bus_rdata[7:0]` and the second to `bus_rdata[15:8]`.
- R5: A byte access to offset 0 (`bus_wide`=0) makes exactly one byte cycle. A write sends `bus_wdata[7:0]`. A read returns the byte in `bus_rdata[7:0]` with bits 15:8 zero.
- R6: `bus_wait` rises in the clock after an accepted data-port request. It stays high for bytes×(`STROBE_CLKS`+`GAP_CLKS`) clocks, and the read result is on `bus_rdata` when it falls. A request made while `bus_wait` is high is ignored.
- R7: Status (offset 5) bit 7 reads 1 while the synchronized `nf_rb` is low (busy), and its other bits read 0. The pin reaches the status bit through a two-flop synchronizer.
- R8: A rising edge of the synchronized `nf_rb` sets interrupt status bit 0. A falling edge sets nothing. Interrupt status bits 3:1 have no source and read 0.
- R9: `irq` is high when mask bit 7 is set and some interrupt status bit is set whose mask bit among bits 3:0 is also set. So 0x81 enables the ready event, while 0x00 and 0x01 leave `irq` low.
- R10: A write to the interrupt status register clears each bit written as 1 and keeps each bit written as 0, so 0x0F clears all four.
- R11: A register read of offsets 4 to 7 puts its value on `bus_rdata[7:0]` in the clock after the request, without raising `bus_wait`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One-clock access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | Data port: 1 = word access, 0 = byte access |
| bus_addr | input | 3 | Byte offset: 0 data, 4 mode, 5 status, 6 interrupt status, 7 interrupt mask |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_wait | output | 1 | High while a data-port transfer runs |
| irq | output | 1 | Interrupt request |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Flash command latch enable |
| nf_ale | output | 1 | Flash address latch enable |
| nf_wen_n | output | 1 | Write-permit level, low when mode bit 7 is set |
| nf_pwr | output | 2 | Card power control bits |
| nf_wstb_n | output | 1 | Flash write strobe, active low |
| nf_rstb_n | output | 1 | Flash read strobe, active low |
| nf_dout | output | 8 | Flash data out |
| nf_doe | output | 1 | Flash data output enable |
| nf_din | input | 8 | Flash data in |
| nf_rb | input | 1 | Flash ready/busy, 1 = ready |

## Verification
A register read result is due in the clock after the request edge. Pin changes from a mode write show up on the same edge. A data transfer follows a fixed timetable. The strobe goes low right after the request edge, and each byte slot is `STROBE_CLKS`+`GAP_CLKS` clocks long. `bus_wait` is seen low at the first falling edge after the last slot. The bench drives on falling edges and samples on falling edges. It walks that timetable one clock at a time, checking the strobe level, the data out and the wait level in every slot, and it changes `nf_din` at the start of each read slot. Ready-line changes need two synchronizer clocks plus an edge-detect clock, so the bench waits four clocks before reading status or interrupt state.

// File: rtl/nhb_pkg.sv
package nhb_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_STROBE = 2'd1,
      PH_GAP    = 2'd2
   } nhb_phase_e;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_MODE = 3'd4;
   localparam logic [ADDR_W-1:0] OFS_STAT = 3'd5;
   localparam logic [ADDR_W-1:0] OFS_ISR  = 3'd6;
   localparam logic [ADDR_W-1:0] OFS_IMR  = 3'd7;

   localparam int MB_CLE    = 0;
   localparam int MB_ALE    = 1;
   localparam int MB_PWR_LO = 2;
   localparam int MB_CE     = 4;
   localparam int MB_WE     = 7;
   localparam int SB_BUSY   = 7;
   localparam int IMR_MSTR  = 7;

   function automatic int nhb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nhb_rb_monitor.sv
module nhb_rb_monitor
   import nhb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int EVT_BITS    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rb_pin,
   input  logic                isr_clr_we,
   input  logic [EVT_BITS-1:0] clr_mask,
   input  logic                imr_we,
   input  logic [7:0]          imr_wdata,
   output logic                rb_busy,
   output logic [EVT_BITS-1:0] isr_q,
   output logic [7:0]          imr_q,
   output logic                irq
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("nhb_rb_monitor: SYNC_STAGES must be at least 2");
   end
   if (EVT_BITS < 1 || EVT_BITS > 7) begin : g_bad_evt
      $error("nhb_rb_monitor: EVT_BITS must be 1..7");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rb_sync;
   logic                   rb_prev_q;
   logic                   rb_rise;
   logic [EVT_BITS-1:0]    evt_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q    <= '1;
         rb_prev_q <= 1'b1;
      end else begin
         sync_q    <= {sync_q[SYNC_STAGES-2:0], rb_pin};
         rb_prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rb_sync = sync_q[SYNC_STAGES-1];
   assign rb_rise = rb_sync & ~rb_prev_q;
   assign rb_busy = ~rb_sync;

   always_comb begin
      evt_src    = '0;
      evt_src[0] = rb_rise;
   end

   for (genvar i = 0; i < EVT_BITS; i++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            isr_q[i] <= 1'b0;
         end else begin
            isr_q[i] <= (isr_q[i] & ~(isr_clr_we & clr_mask[i])) | evt_src[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q <= '0;
      end else if (imr_we) begin
         imr_q <= imr_wdata;
      end
   end

   assign irq = imr_q[IMR_MSTR] & (|(isr_q & imr_q[EVT_BITS-1:0]));

   // R8
   evt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_q[0]) |-> $past(rb_sync));

   // R10
   evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isr_clr_we && clr_mask[0] && !rb_rise) |=> !isr_q[0]);

endmodule

// File: rtl/nhb_byte_engine.sv
module nhb_byte_engine
   import nhb_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int STROBE_CLKS = 3,
   parameter int GAP_CLKS    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_wr,
   input  logic              start_wide,
   input  logic [DATA_W-1:0] start_wdata,
   input  logic [7:0]        nf_din,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_word,
   output logic              nf_wstb_n,
   output logic              nf_rstb_n,
   output logic [7:0]        nf_dout,
   output logic              nf_doe
);

   localparam int BYTES   = DATA_W / 8;
   localparam int IDX_W   = (BYTES > 1) ? $clog2(BYTES) : 1;
   localparam int CNT_MAX = nhb_max(STROBE_CLKS, GAP_CLKS);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_w
      $error("nhb_byte_engine: DATA_W must be a multiple of 8, at least 16");
   end
   if (STROBE_CLKS < 1 || GAP_CLKS < 1) begin : g_bad_t
      $error("nhb_byte_engine: strobe and gap lengths must be at least 1");
   end

   nhb_phase_e        phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_q;
   logic              wr_q;
   logic [DATA_W-1:0] wbuf_q;
   logic [7:0]        lane_q [BYTES];
   logic              strobe_end;
   logic              gap_end;
   logic              cap_en;

   assign strobe_end = (phase_q == PH_STROBE) && (cnt_q == CNT_W'(STROBE_CLKS - 1));
   assign gap_end    = (phase_q == PH_GAP) && (cnt_q == CNT_W'(GAP_CLKS - 1));
   assign cap_en     = strobe_end && !wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         last_q  <= '0;
         wr_q    <= 1'b0;
         wbuf_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= PH_STROBE;
                  cnt_q   <= '0;
                  idx_q   <= '0;
                  last_q  <= start_wide ? IDX_W'(BYTES - 1) : '0;
                  wr_q    <= start_wr;
                  wbuf_q  <= start_wdata;
               end
            end
            PH_STROBE: begin
               if (strobe_end) begin
                  phase_q <= PH_GAP;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_GAP: begin
               if (gap_end) begin
                  cnt_q <= '0;
                  if (idx_q == last_q) begin
                     phase_q <= PH_IDLE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     phase_q <= PH_STROBE;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q[g] <= '0;
         end else if (start && phase_q == PH_IDLE) begin
            lane_q[g] <= '0;
         end else if (cap_en && idx_q == IDX_W'(g)) begin
            lane_q[g] <= nf_din;
         end
      end
      assign rd_word[g*8 +: 8] = lane_q[g];
   end

   assign busy      = (phase_q != PH_IDLE);
   assign done      = gap_end && (idx_q == last_q);
   assign nf_wstb_n = !((phase_q == PH_STROBE) && wr_q);
   assign nf_rstb_n = !((phase_q == PH_STROBE) && !wr_q);
   assign nf_doe    = busy && wr_q;
   assign nf_dout   = wbuf_q[idx_q*8 +: 8];

   if (STROBE_CLKS > 1) begin : g_width_chk
      // R3
      strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(nf_wstb_n) |=> !nf_wstb_n);
   end

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (nf_wstb_n && nf_rstb_n && !nf_doe));

   // R4
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nf_rstb_n) |-> $past(cap_en));

endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
   import nhb_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int STROBE_CLKS = 3,
   parameter int GAP_CLKS    = 1,
   parameter int SYNC_STAGES = 2,
   parameter int EVT_BITS    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic              bus_wide,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_wait,
   output logic              irq,
   output logic              nf_ce_n,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_wen_n,
   output logic [1:0]        nf_pwr,
   output logic              nf_wstb_n,
   output logic              nf_rstb_n,
   output logic [7:0]        nf_dout,
   output logic              nf_doe,
   input  logic [7:0]        nf_din,
   input  logic              nf_rb
);

   logic [7:0]          mode_q;
   logic [DATA_W-1:0]   rdata_q;
   logic                data_rd_q;
   logic                acc;
   logic                data_acc;
   logic                eng_busy;
   logic                eng_done;
   logic [DATA_W-1:0]   eng_word;
   logic                rb_busy;
   logic [EVT_BITS-1:0] isr_q;
   logic [7:0]          imr_q;
   logic                isr_clr_we;
   logic                imr_we;
   logic [7:0]          reg_val;

   assign acc        = bus_req && !eng_busy;
   assign data_acc   = acc && (bus_addr == OFS_DATA);
   assign isr_clr_we = acc && bus_wr && (bus_addr == OFS_ISR);
   assign imr_we     = acc && bus_wr && (bus_addr == OFS_IMR);

   always_comb begin
      reg_val = 8'h00;
      case (bus_addr)
         OFS_MODE: reg_val = mode_q;
         OFS_STAT: reg_val[SB_BUSY] = rb_busy;
         OFS_ISR:  reg_val[EVT_BITS-1:0] = isr_q;
         OFS_IMR:  reg_val = imr_q;
         default:  reg_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 8'h00;
         rdata_q   <= '0;
         data_rd_q <= 1'b0;
      end else begin
         if (acc && bus_wr && bus_addr == OFS_MODE) begin
            mode_q <= bus_wdata[7:0];
         end
         if (data_acc) begin
            data_rd_q <= !bus_wr;
         end
         if (acc && !bus_wr && bus_addr != OFS_DATA) begin
            rdata_q <= {{(DATA_W-8){1'b0}}, reg_val};
         end else if (eng_done && data_rd_q) begin
            rdata_q <= eng_word;
         end
      end
   end

   nhb_byte_engine #(
      .DATA_W      (DATA_W),
      .STROBE_CLKS (STROBE_CLKS),
      .GAP_CLKS    (GAP_CLKS)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (data_acc),
      .start_wr    (bus_wr),
      .start_wide  (bus_wide),
      .start_wdata (bus_wdata),
      .nf_din      (nf_din),
      .busy        (eng_busy),
      .done        (eng_done),
      .rd_word     (eng_word),
      .nf_wstb_n   (nf_wstb_n),
      .nf_rstb_n   (nf_rstb_n),
      .nf_dout     (nf_dout),
      .nf_doe      (nf_doe)
   );

   nhb_rb_monitor #(
      .SYNC_STAGES (SYNC_STAGES),
      .EVT_BITS    (EVT_BITS)
   ) u_monitor (
      .clk        (clk),
      .rst_n      (rst_n),
      .rb_pin     (nf_rb),
      .isr_clr_we (isr_clr_we),
      .clr_mask   (bus_wdata[EVT_BITS-1:0]),
      .imr_we     (imr_we),
      .imr_wdata  (bus_wdata[7:0]),
      .rb_busy    (rb_busy),
      .isr_q      (isr_q),
      .imr_q      (imr_q),
      .irq        (irq)
   );

   assign bus_rdata = rdata_q;
   assign bus_wait  = eng_busy;
   assign nf_ce_n   = ~mode_q[MB_CE];
   assign nf_cle    = mode_q[MB_CLE];
   assign nf_ale    = mode_q[MB_ALE];
   assign nf_wen_n  = ~mode_q[MB_WE];
   assign nf_pwr    = mode_q[MB_PWR_LO +: 2];

   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_wait) |-> $stable(mode_q));

   // R6
   wait_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_wait) |-> ($past(nf_wstb_n) && $past(nf_rstb_n)));

endmodule

// File: tb/sim_nand_host_bridge.sv
`timescale 1ns/1ps
module sim_nand_host_bridge;

   localparam int S = 3;
   localparam int G = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_wide = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_wait;
   logic        irq;
   logic        nf_ce_n, nf_cle, nf_ale, nf_wen_n;
   logic [1:0]  nf_pwr;
   logic        nf_wstb_n, nf_rstb_n, nf_doe;
   logic [7:0]  nf_dout;
   logic [7:0]  nf_din = '0;
   logic        nf_rb = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   nand_host_bridge #(
      .DATA_W(16), .STROBE_CLKS(S), .GAP_CLKS(G), .SYNC_STAGES(2), .EVT_BITS(4)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_wait(bus_wait), .irq(irq),
      .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_wen_n(nf_wen_n),
      .nf_pwr(nf_pwr), .nf_wstb_n(nf_wstb_n), .nf_rstb_n(nf_rstb_n),
      .nf_dout(nf_dout), .nf_doe(nf_doe), .nf_din(nf_din), .nf_rb(nf_rb)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = {8'h00, d};
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata[7:0];
   endtask

   task automatic data_xfer(input bit wr, input bit wide, input logic [15:0] wd,
                            input logic [15:0] fl, input string tag);
      int nb;
      logic [15:0] exp_rd;
      nb = wide ? 2 : 1;
      exp_rd = wide ? fl : {8'h00, fl[7:0]};
      @(negedge clk);
      bus_req = 1'b1; bus_wr = wr; bus_wide = wide; bus_addr = 3'd0; bus_wdata = wd;
      @(negedge clk);
      bus_req = 1'b0;
      for (int b = 0; b < nb; b++) begin
         for (int k = 0; k < S + G; k++) begin
            if (k == 0) nf_din = fl[b*8 +: 8];
            check({tag, " R6 wait"}, {15'd0, bus_wait}, 16'd1);
            if (wr) begin
               check({tag, " R3 wstb"}, {15'd0, nf_wstb_n}, (k < S) ? 16'd0 : 16'd1);
               check({tag, " R3 doe"}, {15'd0, nf_doe}, 16'd1);
               check({tag, " R3 dout"}, {8'd0, nf_dout}, {8'd0, wd[b*8 +: 8]});
            end else begin
               check({tag, " R4 rstb"}, {15'd0, nf_rstb_n}, (k < S) ? 16'd0 : 16'd1);
               check({tag, " R4 wstb idle"}, {15'd0, nf_wstb_n}, 16'd1);
            end
            @(negedge clk);
         end
      end
      check({tag, " R6 wait end"}, {15'd0, bus_wait}, 16'd0);
      if (!wr) check({tag, " R4 rdata"}, bus_rdata, exp_rd);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 ce_n", {15'd0, nf_ce_n}, 16'd1);
      check("R1 cle/ale", {14'd0, nf_cle, nf_ale}, 16'd0);
      check("R1 wen_n", {15'd0, nf_wen_n}, 16'd1);
      check("R1 pwr", {14'd0, nf_pwr}, 16'd0);
      check("R1 wait/irq", {14'd0, bus_wait, irq}, 16'd0);
      reg_rd(3'd6, v); check("R1 isr", {8'd0, v}, 16'd0);
      reg_rd(3'd7, v); check("R1 imr", {8'd0, v}, 16'd0);
      reg_rd(3'd4, v); check("R1 mode", {8'd0, v}, 16'd0);
   endtask

   task automatic t_mode();
      logic [7:0] v;
      reg_wr(3'd4, 8'h95);
      check("R2 cmd pins", {12'd0, nf_ce_n, nf_cle, nf_ale, nf_wen_n}, 16'b0100);
      reg_rd(3'd4, v); check("R11 mode readback", {8'd0, v}, 16'h95);
      check("R11 no wait on reg read", {15'd0, bus_wait}, 16'd0);
      reg_wr(3'd4, 8'h96);
      check("R2 addr pins", {12'd0, nf_ce_n, nf_cle, nf_ale, nf_wen_n}, 16'b0010);
      reg_wr(3'd4, 8'h0C);
      check("R2 power on", {13'd0, nf_pwr, nf_ce_n}, 16'b111);
      reg_wr(3'd4, 8'h08);
      check("R2 power off", {14'd0, nf_pwr}, 16'b10);
      reg_wr(3'd4, 8'h00);
      check("R2 standby", {12'd0, nf_ce_n, nf_cle, nf_ale, nf_wen_n}, 16'b1001);
      reg_wr(3'd4, 8'h94);
      check("R2 data pins", {12'd0, nf_ce_n, nf_cle, nf_ale, nf_wen_n}, 16'b0000);
   endtask

   task automatic t_write16();
      data_xfer(1'b1, 1'b1, 16'hA55A, 16'h0000, "wr16");
      data_xfer(1'b1, 1'b1, 16'h01FE, 16'h0000, "wr16b");
   endtask

   task automatic t_read16();
      data_xfer(1'b0, 1'b1, 16'h0000, 16'hC33C, "rd16");
      data_xfer(1'b0, 1'b1, 16'h0000, 16'h00FF, "rd16b");
   endtask

   task automatic t_byte();
      data_xfer(1'b1, 1'b0, 16'hEE77, 16'h0000, "R5 wr8");
      data_xfer(1'b0, 1'b0, 16'h0000, 16'h991E, "R5 rd8");
   endtask

   task automatic t_ignore();
      logic [7:0] v;
      reg_wr(3'd4, 8'h94);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b1; bus_wide = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h1234;
      @(negedge clk);
      bus_addr = 3'd4; bus_wdata = 16'h0000;
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
      for (int i = 0; i < 2 * (S + G); i++) @(negedge clk);
      check("R6 idle after", {15'd0, bus_wait}, 16'd0);
      check("R6 ignored req ce_n", {15'd0, nf_ce_n}, 16'd0);
      reg_rd(3'd4, v); check("R6 ignored req mode", {8'd0, v}, 16'h94);
   endtask

   task automatic t_status();
      logic [7:0] v;
      @(negedge clk); nf_rb = 1'b0;
      repeat (3) @(negedge clk);
      reg_rd(3'd5, v); check("R7 busy", {8'd0, v}, 16'h80);
      @(negedge clk); nf_rb = 1'b1;
      repeat (3) @(negedge clk);
      reg_rd(3'd5, v); check("R7 ready", {8'd0, v}, 16'h00);
   endtask

   task automatic t_event();
      logic [7:0] v;
      reg_wr(3'd6, 8'h0F);
      @(negedge clk); nf_rb = 1'b0;
      repeat (4) @(negedge clk);
      reg_rd(3'd6, v); check("R8 no event on fall", {8'd0, v}, 16'h00);
      @(negedge clk); nf_rb = 1'b1;
      repeat (4) @(negedge clk);
      reg_rd(3'd6, v); check("R8 event on rise", {8'd0, v}, 16'h01);
      check("R9 masked 0x00", {15'd0, irq}, 16'd0);
      reg_wr(3'd7, 8'h01);
      check("R9 no master 0x01", {15'd0, irq}, 16'd0);
      reg_wr(3'd7, 8'h81);
      check("R9 enabled 0x81", {15'd0, irq}, 16'd1);
      reg_wr(3'd6, 8'h0E);
      reg_rd(3'd6, v); check("R10 keep bit0", {8'd0, v}, 16'h01);
      check("R10 irq kept", {15'd0, irq}, 16'd1);
      reg_wr(3'd6, 8'h0F);
      reg_rd(3'd6, v); check("R10 cleared", {8'd0, v}, 16'h00);
      check("R10 irq low", {15'd0, irq}, 16'd0);
      reg_wr(3'd7, 8'h00);
   endtask

   initial begin
      #(5.0 * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode();
      t_write16();
      t_read16();
      t_byte();
      t_ignore();
      t_status();
      t_event();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule